// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two
independent predictors and a per-branch selector that picks one of them. The
global predictor indexes a table of 2-bit saturating counters with a shift
register that holds the outcomes of the most recent branches. The local
predictor first looks up a per-branch outcome history by branch address. It
then uses that history as the index into a table of 3-bit saturating counters.
A table of 2-bit selector counters, indexed by branch address, decides which of
the two component answers becomes the final prediction.

Lookup is combinational. The fetch logic presents the low address bits of a
branch and reads the final prediction and both component predictions in the
same cycle. When the branch resolves, the caller presents its address bits and
its real outcome with a valid strobe. At that clock edge the block trains the
global counter, the local counter, the per-branch history, the global history
and the selector, all at once. History is only written at resolution, so
nothing has to be repaired after a misprediction.

The branch address ports are as wide as the wider of the two address-indexed
tables. The caller drops any address bits above that width.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, all histories are zero. Every global counter holds 1 (weakly not taken), every local counter holds 3 (weakly not taken), and every selector holds 2 (weakly favours global). So all three prediction outputs read 0 before the first update.
- R2: `pred_glob` is bit 1 (the MSB) of the 2-bit global counter selected by the global history register.
- R3: `pred_loc` comes from a two-step lookup. The per-branch history entry at `lk_pc[LIDX_W-1:0]` selects a 3-bit counter. The prediction is that counter's MSB, so counter values 4 to 7 mean taken.
- R4: The selector entry at `lk_pc[CIDX_W-1:0]` picks the final answer. Values 2 and 3 pass `pred_glob` to `pred_taken`; values 0 and 1 pass `pred_loc`.
- R5: On an update, the global counter and the local counter that the resolving branch would read each move by one: up on taken, down on not taken. They saturate at 0 and at their maximum (3 and 7).
- R6: A selector moves only when exactly one component was right for the resolving branch. It counts up (towards global) when only the global prediction was correct, and down when only the local prediction was correct. It saturates at 0 and 3.
- R7: Each update shifts the real outcome into bit 0 of the global history register. The oldest outcome is dropped.
- R8: Each update shifts the real outcome into bit 0 of the history entry at `up_pc[LIDX_W-1:0]`.
- R9: A lookup in the same cycle as an update sees the state from before that update. The update becomes visible from the next cycle on.
- R10: A cycle without `up_valid` leaves every table and history unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | max(LIDX_W,CIDX_W) | Low address bits of the branch being looked up |
| pred_taken | output | 1 | Final prediction chosen by the selector |
| pred_glob | output | 1 | Global component prediction |
| pred_loc | output | 1 | Local component prediction |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | max(LIDX_W,CIDX_W) | Low address bits of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch |

## Verification
The hardest state to reach from the ports is a selector that walks across its whole range. That needs long runs of branches where one component is right and the other is wrong. Those runs are rare because both components learn from the same outcome stream.

The stimulus builds them on purpose. It interleaves a branch with a short repeating pattern, which the local history learns quickly, with a branch of random outcomes that keeps the global history scrambled. A separate run of outcomes that depend on the previous two outcomes pushes the selector the other way. Small tables in the bench make counter saturation and index aliasing happen within a few hundred updates.

// File: rtl/tp_pkg.sv
package tp_pkg;
   // Selector decision: the MSB of a selector counter.
   typedef enum logic {
      PICK_LOCAL  = 1'b0,
      PICK_GLOBAL = 1'b1
   } tp_pick_e;

   // Selector value after reset: weakly favours the global component.
   localparam logic [1:0] SEL_RST = 2'b10;
endpackage

// File: rtl/tp_ctr_table.sv
// Table of saturating counters.
// One combinational read port returns a counter MSB.
// One update port reads the counter at wr_idx and writes back its saturated step.
module tp_ctr_table #(
   parameter int IDX_W = 12,
   parameter int CTR_W = 2,
   parameter logic [CTR_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_msb,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_en,
   input  logic             wr_taken,
   output logic             wr_msb
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CMAX = '1;

   if (CTR_W < 2) begin : g_bad_width
      initial $error("tp_ctr_table: CTR_W must be at least 2");
   end
   if (IDX_W < 1) begin : g_bad_idx
      initial $error("tp_ctr_table: IDX_W must be at least 1");
   end

   logic [CTR_W-1:0] ctr_q [DEPTH];
   logic [CTR_W-1:0] cur, nxt;

   assign cur = ctr_q[wr_idx];

   always_comb begin
      nxt = cur;
      if (wr_taken && cur != CMAX)
         nxt = cur + CTR_W'(1);
      else if (!wr_taken && cur != '0)
         nxt = cur - CTR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= RST_VAL;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= nxt;
      end
   end

   assign rd_msb = ctr_q[rd_idx][CTR_W-1];
   assign wr_msb = cur[CTR_W-1];
endmodule

// File: rtl/tp_hist_table.sv
// Per-branch outcome histories.
// An update shifts the new outcome into bit 0 of the entry at wr_idx.
module tp_hist_table #(
   parameter int IDX_W  = 10,
   parameter int HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_en,
   input  logic              wr_taken,
   output logic [HIST_W-1:0] wr_hist
);
   localparam int DEPTH = 1 << IDX_W;

   if (HIST_W < 1 || IDX_W < 1) begin : g_bad_cfg
      initial $error("tp_hist_table: widths must be at least 1");
   end

   logic [HIST_W-1:0] hist_q [DEPTH];
   logic [HIST_W-1:0] shifted;

   assign wr_hist = hist_q[wr_idx];
   assign rd_hist = hist_q[rd_idx];

   if (HIST_W == 1) begin : g_one_bit
      assign shifted = wr_taken;
   end else begin : g_multi_bit
      assign shifted = {wr_hist[HIST_W-2:0], wr_taken};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      end else if (wr_en) begin
         hist_q[wr_idx] <= shifted;
      end
   end
endmodule

// File: rtl/tp_chooser.sv
// Table of 2-bit selector counters, one per address-indexed entry.
module tp_chooser
   import tp_pkg::*;
#(
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output tp_pick_e         rd_pick,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_en,
   input  logic             wr_to_glob,
   output logic             wr_sat
);
   localparam int DEPTH = 1 << IDX_W;

   logic [1:0] sel_q [DEPTH];
   logic [1:0] cur;

   assign cur     = sel_q[wr_idx];
   assign wr_sat  = wr_to_glob ? (cur == 2'b11) : (cur == 2'b00);
   assign rd_pick = tp_pick_e'(sel_q[rd_idx][1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) sel_q[i] <= SEL_RST;
      end else if (wr_en) begin
         sel_q[wr_idx] <= wr_to_glob ? cur + 2'd1 : cur - 2'd1;
      end
   end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
   import tp_pkg::*;
#(
   parameter int GHIST_W = 12,
   parameter int LIDX_W  = 10,
   parameter int LHIST_W = 10,
   parameter int CIDX_W  = 12,
   parameter int GCTR_W  = 2,
   parameter int LCTR_W  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic [((LIDX_W > CIDX_W) ? LIDX_W : CIDX_W)-1:0] lk_pc,
   output logic pred_taken,
   output logic pred_glob,
   output logic pred_loc,
   input  logic up_valid,
   input  logic [((LIDX_W > CIDX_W) ? LIDX_W : CIDX_W)-1:0] up_pc,
   input  logic up_taken
);
   if (GHIST_W < 1 || LIDX_W < 1 || LHIST_W < 1 || CIDX_W < 1) begin : g_bad_cfg
      initial $error("tournament_predictor: index widths must be at least 1");
   end

   logic [GHIST_W-1:0] ghist;
   logic [GHIST_W-1:0] ghist_nxt;
   logic [LHIST_W-1:0] lk_lhist, up_lhist;
   logic               g_up_pred, l_up_pred;
   logic               g_ok, l_ok;
   tp_pick_e           pick;
   logic               sel_sat;

   // Global component
   tp_ctr_table #(
      .IDX_W(GHIST_W), .CTR_W(GCTR_W),
      .RST_VAL(GCTR_W'((1 << (GCTR_W - 1)) - 1))
   ) u_glob (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghist), .rd_msb(pred_glob),
      .wr_idx(ghist), .wr_en(up_valid), .wr_taken(up_taken),
      .wr_msb(g_up_pred)
   );

   // Local component: history lookup, then counter lookup
   tp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_pc[LIDX_W-1:0]), .rd_hist(lk_lhist),
      .wr_idx(up_pc[LIDX_W-1:0]), .wr_en(up_valid), .wr_taken(up_taken),
      .wr_hist(up_lhist)
   );

   tp_ctr_table #(
      .IDX_W(LHIST_W), .CTR_W(LCTR_W),
      .RST_VAL(LCTR_W'((1 << (LCTR_W - 1)) - 1))
   ) u_lctr (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_lhist), .rd_msb(pred_loc),
      .wr_idx(up_lhist), .wr_en(up_valid), .wr_taken(up_taken),
      .wr_msb(l_up_pred)
   );

   // Selector
   assign g_ok = (g_up_pred == up_taken);
   assign l_ok = (l_up_pred == up_taken);

   tp_chooser #(.IDX_W(CIDX_W)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_pc[CIDX_W-1:0]), .rd_pick(pick),
      .wr_idx(up_pc[CIDX_W-1:0]),
      .wr_en(up_valid && (g_ok != l_ok) && !sel_sat),
      .wr_to_glob(g_ok),
      .wr_sat(sel_sat)
   );

   assign pred_taken = (pick == PICK_GLOBAL) ? pred_glob : pred_loc;

   // Global history register
   if (GHIST_W == 1) begin : g_gh_one
      assign ghist_nxt = up_taken;
   end else begin : g_gh_multi
      assign ghist_nxt = {ghist[GHIST_W-2:0], up_taken};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ghist <= '0;
      else if (up_valid)
         ghist <= ghist_nxt;
   end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
   parameter int GHIST_W = 12,
   parameter int LIDX_W  = 10,
   parameter int LHIST_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               up_valid,
   input logic               up_taken,
   input logic [LIDX_W-1:0]  lk_lidx,
   input logic [LIDX_W-1:0]  up_lidx,
   input logic               pred_taken,
   input logic               pred_glob,
   input logic               pred_loc,
   input logic [GHIST_W-1:0] ghist,
   input logic [LHIST_W-1:0] lk_lhist
);
   // R1
   hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ghist == '0 && lk_lhist == '0));

   // R7
   ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> ghist[0] == $past(up_taken));

   // R10
   ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(ghist));

   // R4
   agree_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_glob == pred_loc) |-> pred_taken == pred_glob);

   // R8
   lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> (lk_lidx != $past(up_lidx)) || (lk_lhist[0] == $past(up_taken)));
endmodule

bind tournament_predictor tp_checker #(
   .GHIST_W(GHIST_W), .LIDX_W(LIDX_W), .LHIST_W(LHIST_W)
) u_tp_checker (
   .clk(clk), .rst_n(rst_n),
   .up_valid(up_valid), .up_taken(up_taken),
   .lk_lidx(lk_pc[LIDX_W-1:0]), .up_lidx(up_pc[LIDX_W-1:0]),
   .pred_taken(pred_taken), .pred_glob(pred_glob), .pred_loc(pred_loc),
   .ghist(ghist), .lk_lhist(lk_lhist)
);

// File: tb/test_tournament_predictor.sv
module test_tournament_predictor;
   localparam int GH = 4, LI = 2, LH = 3, CI = 3;
   localparam int IW = (LI > CI) ? LI : CI;
   localparam int GDEP = 1 << GH, LDEP = 1 << LI, LCDEP = 1 << LH, CDEP = 1 << CI;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [IW-1:0] lk_pc = '0, up_pc = '0;
   logic up_valid = 1'b0, up_taken = 1'b0;
   logic pred_taken, pred_glob, pred_loc;

   always #5 clk = ~clk;

   tournament_predictor #(
      .GHIST_W(GH), .LIDX_W(LI), .LHIST_W(LH), .CIDX_W(CI), .GCTR_W(2), .LCTR_W(3)
   ) i_tournament_predictor (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
      .pred_taken(pred_taken), .pred_glob(pred_glob), .pred_loc(pred_loc),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // Behavioural reference state
   int m_gh;
   int m_gt [GDEP];
   int m_lt [LCDEP];
   int m_lh [LDEP];
   int m_ch [CDEP];

   function void m_reset();
      m_gh = 0;
      foreach (m_gt[i]) m_gt[i] = 1;
      foreach (m_lt[i]) m_lt[i] = 3;
      foreach (m_lh[i]) m_lh[i] = 0;
      foreach (m_ch[i]) m_ch[i] = 2;
   endfunction

   function int m_g();
      return (m_gt[m_gh] >= 2) ? 1 : 0;
   endfunction

   function int m_l(int pc);
      return (m_lt[m_lh[pc % LDEP]] >= 4) ? 1 : 0;
   endfunction

   function int m_t(int pc);
      return (m_ch[pc % CDEP] >= 2) ? m_g() : m_l(pc);
   endfunction

   function void m_upd(int pc, int tk);
      int li, hv, ci, gp, lp;
      li = pc % LDEP;
      hv = m_lh[li];
      ci = pc % CDEP;
      gp = (m_gt[m_gh] >= 2) ? 1 : 0;
      lp = (m_lt[hv] >= 4) ? 1 : 0;
      if (gp == tk && lp != tk && m_ch[ci] < 3) m_ch[ci]++;
      if (gp != tk && lp == tk && m_ch[ci] > 0) m_ch[ci]--;
      if (tk == 1) begin
         if (m_gt[m_gh] < 3) m_gt[m_gh]++;
         if (m_lt[hv] < 7) m_lt[hv]++;
      end else begin
         if (m_gt[m_gh] > 0) m_gt[m_gh]--;
         if (m_lt[hv] > 0) m_lt[hv]--;
      end
      m_lh[li] = ((hv << 1) | tk) % LCDEP;
      m_gh = ((m_gh << 1) | tk) % GDEP;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, compare, then let the rising edge commit.
   task automatic step(string ph, int lpc, int uv, int upc, int tk);
      @(negedge clk);
      lk_pc = IW'(lpc);
      up_valid = (uv != 0);
      up_pc = IW'(upc);
      up_taken = (tk != 0);
      #1;
      chk({ph, " R2 global"}, int'(pred_glob), m_g());
      chk({ph, " R3 local"}, int'(pred_loc), m_l(lpc));
      chk({ph, " R4 final"}, int'(pred_taken), m_t(lpc));
      @(posedge clk);
      if (uv != 0) m_upd(upc, tk);
   endtask

   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state visible at the ports
      chk("R1 reset pred_glob", int'(pred_glob), 0);
      chk("R1 reset pred_loc", int'(pred_loc), 0);
      chk("R1 reset pred_taken", int'(pred_taken), 0);

      // R1 / R10: lookups with no updates
      for (int i = 0; i < 8; i++) step("R1 idle", i, 0, 0, 0);

      // R5: saturation up then down on one branch
      for (int i = 0; i < 12; i++) step("R5 sat-up", 5, 1, 5, 1);
      for (int i = 0; i < 12; i++) step("R5 sat-down", 5, 1, 5, 0);

      // R8: alternating outcomes learned through local history
      for (int i = 0; i < 40; i++) step("R8 alternate", 1, 1, 1, i % 2);

      // R6: periodic branch interleaved with a random one
      for (int i = 0; i < 300; i++) begin
         if (i % 2 == 0) step("R6 periodic", 3, 1, 3, ((i / 2) % 3 != 2) ? 1 : 0);
         else            step("R6 random", 3, 1, 2, $urandom_range(1, 0));
      end

      // R7: outcome depends on the previous two outcomes
      begin
         int a = 1, b = 0;
         for (int i = 0; i < 150; i++) begin
            int o;
            o = (a ^ b) ^ 1;
            step("R7 correlated", 4, 1, 4, o);
            b = a;
            a = o;
         end
      end

      // R9: lookup and update of the same branch in one cycle
      for (int i = 0; i < 120; i++) begin
         int p;
         p = $urandom_range(IW == 0 ? 0 : (1 << IW) - 1, 0);
         step("R9 same-cycle", p, 1, p, $urandom_range(1, 0));
      end

      // R10: no updates, state must hold
      for (int i = 0; i < 24; i++) step("R10 hold", i % (1 << IW), 0, $urandom_range(7, 0), 1);

      // Mixed random traffic
      for (int i = 0; i < 2000; i++)
         step("R6 mixed", $urandom_range((1 << IW) - 1, 0), $urandom_range(3, 0) != 0 ? 1 : 0,
              $urandom_range((1 << IW) - 1, 0), $urandom_range(1, 0));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1..: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule